// File: doc/BRIEF.md
# SPI Transmit Holding Buffer

This block sits between a host register-write port and a serial shift register. The host hands it transmit words of up to 16 bits, right-justified. When the shifter is idle and nothing is waiting, a word goes straight to the shifter in the cycle it is written. When the shifter is busy, the word waits in a single-entry holding register. It is handed over as soon as the shifter reports idle.

A full flag tells the host that the holding register is occupied. The flag appears in a 32-bit status word. A global enable input gates the whole path. While it is low, host writes are refused and no load strobes are issued. Dropping it also empties the holding register and forces its contents to zero.

Top module: `txHoldBuf`

## Requirements
- R1: After reset the full flag is 0, the load strobe is 0 and the status word is all zeros.
- R2: When enable is 1, a write arrives, the shifter is idle (shiftBusy=0) and the buffer is empty, then in that same cycle loadStb=1 and loadData equals the written word, and the full flag stays 0.
- R3: When enable is 1, a write arrives, the shifter is busy and the buffer is empty, then no load strobe is issued and the full flag is 1 from the next cycle on.
- R4: While the buffer is full, enable is 1 and shiftBusy=0, loadStb=1 with loadData equal to the held word in that cycle. The full flag is 0 in the next cycle unless a new write is captured.
- R5: A write that arrives while the buffer is full and the shifter is busy is dropped. The full flag stays 1, and the word later handed to the shifter is the earlier one.
- R6: A write in the same cycle as a hand-over from the buffer is captured. The held word goes to the shifter, the new word is then held, and the full flag stays 1.
- R7: While enable is 0, writes are ignored and loadStb stays 0.
- R8: While enable is 0, the buffer is emptied. From the next cycle the full flag is 0, and the held word reads as zero on loadData while no strobe is issued.
- R9: Status word bit 29 equals the full flag. All other status bits are 0.
- R10: All 16 data bits pass unchanged, for example 16'hFFFF and 16'h0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Global peripheral enable |
| wrValid | input | 1 | Host write strobe |
| wrData | input | 16 | Right-justified host transmit word |
| shiftBusy | input | 1 | Shifter occupied with a character |
| loadStb | output | 1 | Load strobe to the shifter |
| loadData | output | 16 | Word for the shifter (held word when no strobe) |
| txFull | output | 1 | Holding register occupied |
| statusWord | output | 32 | Status word, bit 29 = full |

## Verification
The hardest case to reach is a host write that lands in the very cycle the shifter frees up while the buffer is still occupied. To reach it, the bench first fills the buffer with the shifter held busy. It then drops shiftBusy and raises wrValid on the same edge. Dropping a write against a full, busy buffer is checked in a similar way. The bench then releases the shifter and checks which word emerges.

// File: rtl/txHoldPkg.sv
package txHoldPkg;
  typedef struct packed {
    logic capture;
    logic bypass;
    logic clear;
  } txCtl_t;
endpackage

// File: rtl/txHoldCtrl.sv
module txHoldCtrl
  import txHoldPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   enable,
  input  logic   wrValid,
  input  logic   shiftBusy,
  output txCtl_t ctl,
  output logic   loadStb,
  output logic   full
);
  logic wrOk, drain, fullNext;

  always_comb begin
    wrOk        = wrValid && enable;
    drain       = enable && full && !shiftBusy;
    ctl.clear   = !enable;
    ctl.bypass  = wrOk && !full && !shiftBusy;
    ctl.capture = wrOk && (full ? !shiftBusy : shiftBusy);
    loadStb     = drain || ctl.bypass;
    if (ctl.clear)        fullNext = 1'b0;
    else if (ctl.capture) fullNext = 1'b1;
    else if (drain)       fullNext = 1'b0;
    else                  fullNext = full;
  end

  always_ff @(posedge clk) begin
    if (!rstN) full <= 1'b0;
    else       full <= fullNext;
  end

  // R7: no strobe while disabled
  a_r7_no_load_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !loadStb);
  // R8: disabling empties the buffer
  a_r8_disable_empties: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !full);
  // R5: full and busy keeps full
  a_r5_hold_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    (enable && full && shiftBusy) |=> full);
  // R4: full and idle shifter hands over
  a_r4_drain: assert property (@(posedge clk) disable iff (!rstN)
    (enable && full && !shiftBusy) |-> loadStb);
endmodule

// File: rtl/txHoldData.sv
module txHoldData
  import txHoldPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  txCtl_t            ctl,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] loadData
);
  logic [DATA_W-1:0] holdReg;

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clear) holdReg <= '0;
    else if (ctl.capture)   holdReg <= wrData;
  end

  assign loadData = ctl.bypass ? wrData : holdReg;

  // R8: clear zeroes the held word
  a_r8_zeroed: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clear |=> (loadData == '0 || ctl.bypass));
  // R6: captured word held next cycle
  a_r6_captured: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capture && !ctl.clear) |=> (holdReg == $past(wrData)));
endmodule

// File: rtl/txHoldBuf.sv
module txHoldBuf
  import txHoldPkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int STAT_W   = 32,
  parameter int FULL_BIT = 29
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  input  logic              shiftBusy,
  output logic              loadStb,
  output logic [DATA_W-1:0] loadData,
  output logic              txFull,
  output logic [STAT_W-1:0] statusWord
);
  txCtl_t ctl;

  txHoldCtrl uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .wrValid(wrValid),
    .shiftBusy(shiftBusy), .ctl(ctl), .loadStb(loadStb), .full(txFull)
  );

  txHoldData #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(wrData), .loadData(loadData)
  );

  always_comb begin
    statusWord = '0;
    statusWord[FULL_BIT] = txFull;
  end

  // R2: bypass carries the written word
  a_r2_bypass_data: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && !txFull) |-> (loadData == wrData));
  // R3: busy write into empty buffer sets full
  a_r3_capture: assert property (@(posedge clk) disable iff (!rstN)
    (enable && wrValid && shiftBusy && !txFull) |=> txFull);
endmodule

// File: tb/tb_txHoldBuf.sv
module tb_txHoldBuf;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rstN = 0, enable = 0, wrValid = 0, shiftBusy = 0;
  logic [15:0] wrData = '0;
  logic loadStb, txFull;
  logic [15:0] loadData;
  logic [31:0] statusWord;
  int nChecks = 0, nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txHoldBuf dut (.clk(clk), .rstN(rstN), .enable(enable), .wrValid(wrValid),
    .wrData(wrData), .shiftBusy(shiftBusy), .loadStb(loadStb),
    .loadData(loadData), .txFull(txFull), .statusWord(statusWord));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at the falling edge, settle before sampling
  task automatic drive(input logic en, input logic wv, input logic [15:0] wd, input logic busy);
    @(negedge clk);
    enable = en; wrValid = wv; wrData = wd; shiftBusy = busy;
    #1;
  endtask

  task automatic t_reset();
    rstN = 0;
    drive(1, 0, 0, 0);
    drive(1, 0, 0, 0);
    check(txFull == 0, "R1 full", txFull, 0);
    check(loadStb == 0, "R1 strobe", loadStb, 0);
    check(statusWord == 0, "R1 status", statusWord, 0);
    rstN = 1;
  endtask

  task automatic t_bypass();
    drive(1, 1, 16'hFFFF, 0);
    check(loadStb == 1, "R2 strobe", loadStb, 1);
    check(loadData == 16'hFFFF, "R10 data FFFF", loadData, 16'hFFFF);
    drive(1, 1, 16'h0001, 0);
    check(txFull == 0, "R2 full stays 0", txFull, 0);
    check(loadData == 16'h0001, "R10 data 0001", loadData, 16'h0001);
    drive(1, 0, 0, 0);
    check(txFull == 0, "R2 full", txFull, 0);
  endtask

  task automatic t_holdDrop();
    drive(1, 1, 16'hA5A5, 1);
    check(loadStb == 0, "R3 no strobe", loadStb, 0);
    drive(1, 1, 16'h1234, 1);
    check(txFull == 1, "R3 full set", txFull, 1);
    check(statusWord == 32'h2000_0000, "R9 status bit29", statusWord, 32'h2000_0000);
    drive(1, 0, 0, 1);
    check(txFull == 1, "R5 full kept", txFull, 1);
    drive(1, 0, 0, 0);
    check(loadStb == 1, "R4 strobe", loadStb, 1);
    check(loadData == 16'hA5A5, "R5 first word kept", loadData, 16'hA5A5);
    drive(1, 0, 0, 1);
    check(txFull == 0, "R4 full cleared", txFull, 0);
    check(statusWord == 0, "R9 status clear", statusWord, 0);
  endtask

  task automatic t_concurrent();
    drive(1, 1, 16'h1111, 1);
    drive(1, 1, 16'h2222, 0);
    check(loadStb == 1 && loadData == 16'h1111, "R6 held word out", loadData, 16'h1111);
    drive(1, 0, 0, 1);
    check(txFull == 1, "R6 full stays", txFull, 1);
    drive(1, 0, 0, 0);
    check(loadStb == 1 && loadData == 16'h2222, "R6 new word out", loadData, 16'h2222);
    drive(1, 0, 0, 1);
    check(txFull == 0, "R6 empty after", txFull, 0);
  endtask

  task automatic t_disable();
    drive(1, 1, 16'h3333, 1);
    drive(0, 1, 16'h4444, 0);
    check(loadStb == 0, "R7 no strobe disabled", loadStb, 0);
    drive(0, 0, 0, 0);
    check(txFull == 0, "R8 full cleared", txFull, 0);
    check(loadData == 0, "R8 data zeroed", loadData, 0);
    drive(1, 0, 0, 0);
    check(loadStb == 0, "R8 nothing left", loadStb, 0);
    drive(0, 1, 16'h5555, 1);
    drive(1, 0, 0, 1);
    check(txFull == 0, "R7 write ignored", txFull, 0);
    check(loadData == 0, "R7 data untouched", loadData, 0);
  endtask

  initial begin
    t_reset();
    t_bypass();
    t_holdDrop();
    t_concurrent();
    t_disable();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule